// File: doc/BRIEF.md
# Multi-mode FSK tone generator

This block turns a 3.579545 MHz reference clock into a sampled sine tone whose frequency is chosen by a 2-bit operating mode and a single data bit. It feeds an external DAC with 8-bit offset-binary codes, one per clock. A 24-bit phase accumulator advances by a constant step that depends on the mode and the data bit. The top bits of the phase then address a quarter-wave sine table. The table is folded by quadrant, so a single table covers the full cycle.

Three of the four modes produce tones. The forward mode carries the 1200 bps signalling tones. The two back-channel modes produce low tones, and one of them signals a 0 by sending no tone at all. In that case, and in the idle (sleep) mode, the output rests at mid-scale and the phase is cleared. The next tone therefore starts from zero phase. A change of data bit or of tone mode changes only the step, so the waveform continues without a phase jump.

Top module: `fsk_tone_gen`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), `sample_o` is 128 and `sample_vld_o` is 0.
- R2: Mode 2'b01 (mode_i[1] is the high bit) uses step 5624 for data 1 (about 1199.9 Hz) and step 10311 for data 0 (about 2199.9 Hz). The measured tone period stays inside the 1197–1203 Hz and 2196–2204 Hz bands respectively.
- R3: Mode 2'b00 uses step 1814 for data 1 (about 387.0 Hz) and step 2283 for data 0 (about 487.1 Hz). Each measured period stays within ±2 Hz of 387 Hz and 487 Hz.
- R4: In mode 2'b10, data 1 gives the 387 Hz tone (step 1814). Data 0 gives no tone: from the next edge on, `sample_o` is 128 and `sample_vld_o` is 1.
- R5: Mode 2'b11 is idle: from the next edge on, `sample_o` is 128 and `sample_vld_o` is 0. In every other mode, `sample_vld_o` is 1 one edge after the mode is applied.
- R6: In a tone mode, each sample is 128 + round(127·sin(π(2k+1)/128)) ±1. Here k is bits [23:17] of the accumulator before the edge, and the accumulator then advances by the step. The full swing of a tone reaches 255 and 1.
- R7: A change of data bit, or of one tone mode to another, keeps the accumulator value. Consecutive samples of a running tone never differ by more than 8.
- R8: Entering the 0 Hz state or idle clears the accumulator. The first sample after tone resumes is 131 (zero phase, k = 0), and the samples after it follow R6 from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 low back-channel, 01 forward, 10 slow back-channel, 11 idle |
| data_i | input | 1 | Data bit selecting mark (1) or space (0) |
| sample_o | output | 8 | Offset-binary sample, mid-scale 128 |
| sample_vld_o | output | 1 | High when the generator is active (not idle) |

## Verification
The step change and the accumulator wrap can fall on the same edge: the new step is added at the very edge where the phase rolls over from the last quadrant into the first. The bench provokes this by watching its own copy of the phase and toggling the data bit in the cycle just before the wrap. The result is judged by matching every following sample to the phase model and by the bound on the step between samples. A second coincidence is a return to tone on the edge that ends a park. There the cleared phase and the fresh step meet, and the first sample must be the zero-phase code.

// File: rtl/fskgen_pkg.sv
package fskgen_pkg;

    typedef enum logic [1:0] {
        MODE_BC150   = 2'b00,
        MODE_FWD1200 = 2'b01,
        MODE_BC5     = 2'b10,
        MODE_SLEEP   = 2'b11
    } fsk_mode_e;

    // Rounded phase step for a tone of f_hz with an acc_w-bit accumulator.
    function automatic longint unsigned tone_step(longint unsigned f_hz,
                                                  longint unsigned clk_hz,
                                                  int unsigned     acc_w);
        return ((f_hz << acc_w) + clk_hz / 2) / clk_hz;
    endfunction

    // Quarter-wave amplitude at the centre of entry i of q entries,
    // rational sine approximation, scaled to peak and rounded.
    function automatic int unsigned qwave_amp(int unsigned i,
                                              int unsigned q,
                                              int unsigned peak);
        longint unsigned t, n, p, num, den;
        t   = 2 * longint'(i) + 1;
        n   = 4 * longint'(q);
        p   = t * (n - t);
        num = 16 * p * peak;
        den = 5 * n * n - 4 * p;
        return 32'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/fsk_step_sel.sv
module fsk_step_sel
    import fskgen_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 3579545,
    parameter int unsigned PHASE_W     = 24,
    parameter int unsigned F_FWD_MARK  = 1200,
    parameter int unsigned F_FWD_SPACE = 2200,
    parameter int unsigned F_BC_MARK   = 387,
    parameter int unsigned F_BC_SPACE  = 487
) (
    input  logic [1:0]         mode_i,
    input  logic               data_i,
    output logic [PHASE_W-1:0] step_o,
    output logic               park_o,
    output logic               active_o
);
    localparam logic [PHASE_W-1:0] STEP_FM = PHASE_W'(tone_step(F_FWD_MARK, CLK_HZ, PHASE_W));
    localparam logic [PHASE_W-1:0] STEP_FS = PHASE_W'(tone_step(F_FWD_SPACE, CLK_HZ, PHASE_W));
    localparam logic [PHASE_W-1:0] STEP_BM = PHASE_W'(tone_step(F_BC_MARK, CLK_HZ, PHASE_W));
    localparam logic [PHASE_W-1:0] STEP_BS = PHASE_W'(tone_step(F_BC_SPACE, CLK_HZ, PHASE_W));

    always_comb begin
        step_o   = '0;
        park_o   = 1'b0;
        active_o = 1'b1;
        unique case (fsk_mode_e'(mode_i))
            MODE_FWD1200: step_o = data_i ? STEP_FM : STEP_FS;
            MODE_BC150:   step_o = data_i ? STEP_BM : STEP_BS;
            MODE_BC5: begin
                step_o = STEP_BM;
                park_o = !data_i;
            end
            MODE_SLEEP: begin
                park_o   = 1'b1;
                active_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fsk_quarter_lut.sv
module fsk_quarter_lut
    import fskgen_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int AMP_W  = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [AMP_W-1:0]  amp_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PEAK  = (1 << AMP_W) - 1;

    logic [AMP_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = AMP_W'(qwave_amp(g, DEPTH, PEAK));
    end

    assign amp_o = rom[addr_i];
endmodule

// File: rtl/fsk_wave_fold.sv
module fsk_wave_fold #(
    parameter int ADDR_W   = 5,
    parameter int SAMPLE_W = 8
) (
    input  logic [ADDR_W+1:0]   top_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    localparam int AMP_W = SAMPLE_W - 1;
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic [1:0]        quad;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] addr;
    logic [AMP_W-1:0]  amp;

    assign quad = top_i[ADDR_W+1 -: 2];
    assign idx  = top_i[ADDR_W-1:0];
    assign addr = quad[0] ? ~idx : idx;

    fsk_quarter_lut #(
        .ADDR_W(ADDR_W),
        .AMP_W (AMP_W)
    ) u_lut (
        .addr_i(addr),
        .amp_o (amp)
    );

    assign sample_o = quad[1] ? (MID - {1'b0, amp}) : (MID + {1'b0, amp});
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
    import fskgen_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 3579545,
    parameter int unsigned PHASE_W     = 24,
    parameter int unsigned LUT_AW      = 5,
    parameter int unsigned SAMPLE_W    = 8,
    parameter int unsigned F_FWD_MARK  = 1200,
    parameter int unsigned F_FWD_SPACE = 2200,
    parameter int unsigned F_BC_MARK   = 387,
    parameter int unsigned F_BC_SPACE  = 487
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                data_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_vld_o
);
    localparam int unsigned TOP_W = LUT_AW + 2;
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

    typedef struct packed {
        logic [PHASE_W-1:0]  phase;
        logic [SAMPLE_W-1:0] sample;
        logic                vld;
    } gen_state_t;

    gen_state_t          st_d, st_q;
    logic [PHASE_W-1:0]  step;
    logic [PHASE_W-1:0]  phase_q;
    logic                park;
    logic                active;
    logic [SAMPLE_W-1:0] wave;

    fsk_step_sel #(
        .CLK_HZ     (CLK_HZ),
        .PHASE_W    (PHASE_W),
        .F_FWD_MARK (F_FWD_MARK),
        .F_FWD_SPACE(F_FWD_SPACE),
        .F_BC_MARK  (F_BC_MARK),
        .F_BC_SPACE (F_BC_SPACE)
    ) u_step (
        .mode_i  (mode_i),
        .data_i  (data_i),
        .step_o  (step),
        .park_o  (park),
        .active_o(active)
    );

    fsk_wave_fold #(
        .ADDR_W  (LUT_AW),
        .SAMPLE_W(SAMPLE_W)
    ) u_fold (
        .top_i   (st_q.phase[PHASE_W-1 -: TOP_W]),
        .sample_o(wave)
    );

    always_comb begin
        st_d = st_q;
        if (park) begin
            st_d.phase  = '0;
            st_d.sample = MID;
            st_d.vld    = active;
        end else begin
            st_d.phase  = st_q.phase + step;
            st_d.sample = wave;
            st_d.vld    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= '0;
            st_q.sample <= MID;
            st_q.vld    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q      = st_q.phase;
    assign sample_o     = st_q.sample;
    assign sample_vld_o = st_q.vld;
endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
    parameter int unsigned PHASE_W  = 24,
    parameter int unsigned SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_i,
    input logic                data_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                sample_vld_o,
    input logic [PHASE_W-1:0]  phase_q
);
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic                park_in;
    logic [SAMPLE_W-1:0] prev_q;
    logic [SAMPLE_W-1:0] delta;

    assign park_in = (mode_i == 2'b11) || (mode_i == 2'b10 && !data_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= MID;
        else        prev_q <= sample_o;
    end

    assign delta = (sample_o >= prev_q) ? (sample_o - prev_q) : (prev_q - sample_o);

    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b11 |=> (sample_o == MID && !sample_vld_o)); // R5

    AST_VALID_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i != 2'b11 |=> sample_vld_o); // R5

    AST_ZERO_HZ_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && !data_i) |=> (sample_o == MID && sample_vld_o)); // R4

    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        park_in |=> phase_q == '0); // R8

    AST_RESUME_POS: assert property (@(posedge clk) disable iff (!rst_n)
        park_in ##1 !park_in |=> sample_o > MID); // R8

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(park_in) && !$past(park_in, 2)) |-> delta <= SAMPLE_W'(8)); // R7
endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(
    .PHASE_W (PHASE_W),
    .SAMPLE_W(SAMPLE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .data_i      (data_i),
    .sample_o    (sample_o),
    .sample_vld_o(sample_vld_o),
    .phase_q     (phase_q)
);

// File: tb/sim_fsk_tone_gen.sv
`timescale 1ns/1ps
module sim_fsk_tone_gen;
    localparam real CLK_HZ = 3579545.0;
    localparam int unsigned MASK = 32'h00FF_FFFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_r = 2'b11;
    logic       data_r = 1'b1;
    logic [7:0] sample;
    logic       vld;

    always #2 clk = ~clk;

    fsk_tone_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_r),
        .data_i      (data_r),
        .sample_o    (sample),
        .sample_vld_o(vld)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Steps stated in R2, R3, R4
    function automatic int unsigned step_of(logic [1:0] m, logic d);
        case (m)
            2'b01:   return d ? 5624 : 10311;
            2'b00:   return d ? 1814 : 2283;
            2'b10:   return 1814;
            default: return 0;
        endcase
    endfunction

    function automatic bit park_of(logic [1:0] m, logic d);
        return (m == 2'b11) || (m == 2'b10 && !d);
    endfunction

    // Waveform code stated in R6
    function automatic int wave(int unsigned ph);
        int  k;
        real a;
        k = int'((ph >> 17) & 127);
        a = 127.0 * $sin(3.14159265358979 * real'(2 * k + 1) / 128.0);
        return 128 + $rtoi($floor(a + 0.5));
    endfunction

    int unsigned mph = 0;
    int          esmp = 128;
    bit          evld = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mph  = 0;
            esmp = 128;
            evld = 1'b0;
        end else if (park_of(mode_r, data_r)) begin
            mph  = 0;
            esmp = 128;
            evld = (mode_r != 2'b11);
        end else begin
            esmp = wave(mph);
            evld = 1'b1;
            mph  = (mph + step_of(mode_r, data_r)) & MASK;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] m, logic d);
        mode_r = m;
        data_r = d;
    endtask

    // Compare every sample with the phase model for n cycles
    task automatic t_follow(int n, string req);
        int bad = 0;
        int fa = 0;
        int fe = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((int'(sample) - esmp > 1) || (esmp - int'(sample) > 1) || (vld != evld)) begin
                if (bad == 0) begin
                    fa = int'(sample);
                    fe = esmp;
                end
                bad++;
            end
        end
        chk(bad == 0, req, fa, fe);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(2'b01, 1'b1);
        repeat (3) @(negedge clk);
        chk(sample == 8'd128, "R1 sample in reset", int'(sample), 128);
        chk(vld == 1'b0, "R1 valid in reset", int'(vld), 0);
        rst_n = 1'b1;
    endtask

    // Period between two rising mid-scale crossings, from a stated band
    task automatic t_period(logic [1:0] m, logic d, real f, real tol, string req);
        int prev;
        int cnt = 0;
        int found = 0;
        int per = 0;
        int lo = $rtoi(CLK_HZ / (f + tol));
        int hi = $rtoi(CLK_HZ / (f - tol)) + 1;
        drive(m, d);
        @(negedge clk);
        prev = int'(sample);
        for (int i = 0; i < 30000 && found < 2; i++) begin
            @(negedge clk);
            cnt++;
            if (prev < 128 && int'(sample) > 128) begin
                if (found == 1) per = cnt;
                found++;
                cnt = 0;
            end
            prev = int'(sample);
        end
        chk(per >= lo && per <= hi, req, per, (lo + hi) / 2);
    endtask

    task automatic t_swing();
        int mx = 0;
        int mn = 255;
        drive(2'b01, 1'b1);
        for (int i = 0; i < 3100; i++) begin
            @(negedge clk);
            if (int'(sample) > mx) mx = int'(sample);
            if (int'(sample) < mn) mn = int'(sample);
        end
        chk(mx == 255, "R6 peak code", mx, 255);
        chk(mn == 1, "R6 trough code", mn, 1);
    endtask

    task automatic t_zero_hz();
        int bad = 0;
        drive(2'b10, 1'b1);
        repeat (500) @(negedge clk);
        drive(2'b10, 1'b0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sample != 8'd128 || vld != 1'b1) bad++;
        end
        chk(bad == 0, "R4 zero-tone mid-scale with valid", int'(sample), 128);
    endtask

    task automatic t_resume(logic [1:0] m, logic d, string req);
        drive(m, d);
        @(negedge clk);
        chk(int'(sample) >= 130 && int'(sample) <= 132, req, int'(sample), 131);
        t_follow(800, req);
    endtask

    task automatic t_sleep();
        int bad = 0;
        drive(2'b11, 1'b1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sample != 8'd128 || vld != 1'b0) bad++;
        end
        chk(bad == 0, "R5 idle mid-scale, valid low", int'(sample), 128);
    endtask

    // Toggle the data bit repeatedly while a tone runs
    task automatic t_switch();
        int prev;
        int worst = 0;
        drive(2'b01, 1'b1);
        @(negedge clk);
        prev = int'(sample);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (i % 700 == 0) data_r = ~data_r;
            if (int'(sample) - prev > worst) worst = int'(sample) - prev;
            if (prev - int'(sample) > worst) worst = prev - int'(sample);
            prev = int'(sample);
        end
        chk(worst <= 8, "R7 sample step across bit changes", worst, 8);
        t_follow(500, "R7 phase kept across bit changes");
    endtask

    // Step change falls on the edge where the accumulator wraps
    task automatic t_wrap_switch();
        int guard = 0;
        drive(2'b01, 1'b1);
        while (((mph + 5624) & MASK) > mph && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        data_r = 1'b0;
        t_follow(400, "R7 step change on wrap edge");
    endtask

    task automatic t_mode_hop();
        drive(2'b01, 1'b0);
        repeat (1000) @(negedge clk);
        drive(2'b00, 1'b0);
        t_follow(2000, "R7 phase kept across tone mode change");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_resume(2'b01, 1'b1, "R8 first sample after reset release");
        t_follow(4000, "R6 forward mark waveform");
        drive(2'b01, 1'b0);
        t_follow(2000, "R2 forward space waveform");
        t_period(2'b01, 1'b1, 1200.0, 3.0, "R2 mark period");
        t_period(2'b01, 1'b0, 2200.0, 4.0, "R2 space period");
        t_period(2'b00, 1'b1, 387.0, 2.0, "R3 mark period");
        t_period(2'b00, 1'b0, 487.0, 2.0, "R3 space period");
        drive(2'b00, 1'b1);
        t_follow(3000, "R3 back-channel waveform");
        t_period(2'b10, 1'b1, 387.0, 2.0, "R4 slow mark period");
        t_swing();
        t_zero_hz();
        t_resume(2'b10, 1'b1, "R8 restart after zero tone");
        t_sleep();
        t_resume(2'b01, 1'b1, "R8 restart after idle");
        t_switch();
        t_wrap_switch();
        t_mode_hop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule